// File: doc/BRIEF.md
# Pipelined Four-Beat Fill Responder

This block is the responding side of a simple fill protocol. A master raises a one-cycle fill request, and the block answers each request with a burst of four transfer beats on a two-bit response bus. The master does not wait for a burst to finish before it requests the next fill. The block therefore keeps a count of fills still owed and serves them strictly in arrival order. It also flags the final beat of every fill separately, even when bursts follow each other with no idle cycle between them.

A stall input lets the responder insert idle cycles between beats. In a stalled cycle the response shows the idle code and the burst does not advance. There is no back-pressure toward the master: a request is never refused by handshake. A request that finds the pending queue full is dropped, and a sticky overflow flag records the loss. The request and the stall are plain control pins, not a valid/ready stream. The response follows the current stall input in the same cycle, and beats begin the cycle after the first fill is registered.

Top module: `burst_fill_responder`

## Requirements
- R1: While reset is low and right after its release, the response reads IDLE (code 0), and ongoing, done and overflow are all low.
- R2: Only request code 1 (FILL) counts as a fill. Request codes 0, 2 and 3 leave the response and the flags unchanged.
- R3: Every accepted fill yields exactly four cycles with response code 1 (TRANS). In every other cycle the response is code 0 (IDLE).
- R4: When the block is idle and no stall is applied, the first TRANS beat of a fill appears in the cycle after the request cycle.
- R5: A high stall forces IDLE in that cycle and does not move the burst forward. The remaining beats follow once stall is low.
- R6: Fills that arrive while earlier beats are still owed are queued and served in arrival order. A fill that arrives in the cycle of a previous fill's fourth beat is counted, and its first beat follows in the next cycle with no gap.
- R7: Ongoing is high in exactly those cycles in which at least one accepted fill still has beats left to send.
- R8: Done is high for one cycle, together with the fourth TRANS beat of each fill, and in no other cycle.
- R9: Up to 7 fills may be pending. A fill that arrives while 7 are pending, and in a cycle where no fill completes, is dropped and sets overflow. Overflow stays high until reset.
- R10: Reset is asynchronous. Pulling it low in the middle of a burst at once returns the response to IDLE and clears ongoing, done, overflow and all queued work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 2 | Request code from master; 1 = FILL |
| stall | input | 1 | Insert an idle cycle instead of a beat |
| rsp | output | 2 | Response code; 0 = IDLE, 1 = TRANS |
| ongoing | output | 1 | Some fill still owes beats |
| done | output | 1 | Fourth beat of a fill in this cycle |
| overflow | output | 1 | Sticky: a fill was dropped on a full queue |

## Verification
A pending count that is off by one shows as a burst too many or too few. It becomes visible at the ports only when the queue drains and ongoing falls, which can be up to 28 beats later. A wrong beat position shows within the same burst, because done moves away from the fourth TRANS or two bursts merge. A stall that leaks into the beat counter shows as a short burst. For these reasons the sweeps compare total beats, total done pulses and the cycle index of the last beat against values computed from the fill and stall patterns.

// File: rtl/bfr_pkg.sv
`timescale 1ns/1ps
package bfr_pkg;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    REQ_NONE = 2'd0,
    REQ_FILL = 2'd1
  } req_code_e;

  typedef enum logic [CODE_W-1:0] {
    RSP_IDLE = 2'd0,
    RSP_XFER = 2'd1
  } rsp_code_e;
endpackage

// File: rtl/bfr_pending.sv
`timescale 1ns/1ps
module bfr_pending #(
  parameter int PEND_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fill,
  input  logic retire,
  output logic busy,
  output logic ovf
);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [PEND_W-1:0] cnt_q, cnt_d;
  logic              accept;
  logic              drop;

  assign accept = fill && ((cnt_q != PEND_MAX) || retire);
  assign drop   = fill && !accept;
  assign busy   = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (accept && !retire)      cnt_d = cnt_q + 1'b1;
    else if (!accept && retire) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (drop) ovf <= 1'b1;
    end
  end

  AST_RETIRE_NEEDS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> busy); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R9
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == PEND_MAX && fill && !retire) |=> (cnt_q == PEND_MAX && ovf)); // R9
  AST_IDLE_FILL_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && fill) |=> busy); // R4
endmodule

// File: rtl/bfr_beat.sv
`timescale 1ns/1ps
module bfr_beat #(
  parameter int BEATS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic last
);
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [BW-1:0] LAST_IDX = BW'(BEATS - 1);

  logic [BW-1:0] idx_q;

  assign last = go && (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx_q <= '0;
    else if (last) idx_q <= '0;
    else if (go)   idx_q <= idx_q + 1'b1;
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(idx_q)); // R5
  AST_WRAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (idx_q == '0)); // R8
endmodule

// File: rtl/burst_fill_responder.sv
`timescale 1ns/1ps
module burst_fill_responder
  import bfr_pkg::*;
#(
  parameter int BEATS  = 4,
  parameter int PEND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] req,
  input  logic              stall,
  output logic [CODE_W-1:0] rsp,
  output logic              ongoing,
  output logic              done,
  output logic              overflow
);
  logic fill_seen;
  logic busy;
  logic fire;
  logic last_beat;

  assign fill_seen = (req == REQ_FILL);
  assign fire      = busy && !stall;

  bfr_pending #(.PEND_W(PEND_W)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .fill   (fill_seen),
    .retire (last_beat),
    .busy   (busy),
    .ovf    (overflow)
  );

  bfr_beat #(.BEATS(BEATS)) u_beat (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (fire),
    .last  (last_beat)
  );

  assign rsp     = fire ? RSP_XFER : RSP_IDLE;
  assign ongoing = busy;
  assign done    = last_beat;

  AST_STALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (rsp == RSP_IDLE)); // R5
  AST_DONE_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rsp == RSP_XFER)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_BEAT_NEEDS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp == RSP_XFER) |-> ongoing); // R7
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp == RSP_IDLE) || (rsp == RSP_XFER)); // R3
endmodule

// File: tb/sim_burst_fill_responder.sv
`timescale 1ns/1ps
module sim_burst_fill_responder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] req = 2'd0;
  logic       stall = 1'b0;
  logic [1:0] rsp;
  logic       ongoing, done, overflow;

  int checks = 0;
  int errors = 0;
  logic [1:0] o_rsp;
  logic o_on, o_done, o_ovf;

  always #2.5 clk = ~clk;

  burst_fill_responder u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .stall(stall),
    .rsp(rsp), .ongoing(ongoing), .done(done), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at posedge+1: drive, sample mid-cycle, advance to next posedge+1
  task automatic step(input logic [1:0] r, input logic s);
    req = r; stall = s;
    #2;
    o_rsp = rsp; o_on = ongoing; o_done = done; o_ovf = overflow;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = 2'd0; stall = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int beats, dones, last_idx, bad;
    #1;
    // R1: outputs during reset
    chk(rsp == 2'd0 && !ongoing && !done && !overflow, "R1 in reset", rsp, 0);
    do_reset();
    step(2'd0, 1'b0);
    chk(o_rsp == 2'd0 && !o_on && !o_done && !o_ovf, "R1 after release", o_rsp, 0);

    // R2: codes 2 and 3 ignored
    for (int k = 0; k < 6; k++) step((k % 2) ? 2'd3 : 2'd2, 1'b0);
    step(2'd0, 1'b0);
    chk(o_rsp == 2'd0 && !o_on, "R2 codes 2/3 ignored", o_on, 0);

    // R4 R3 R8: single fill
    step(2'd1, 1'b0);
    chk(o_rsp == 2'd0, "R4 idle in request cycle", o_rsp, 0);
    for (int i = 0; i < 4; i++) begin
      step(2'd0, 1'b0);
      chk(o_rsp == 2'd1, "R3 beat of single fill", o_rsp, 1);
      chk(o_done == (i == 3), "R8 done position", o_done, i == 3);
    end
    step(2'd0, 1'b0);
    chk(o_rsp == 2'd0 && !o_on, "R7 ongoing drops after burst", o_on, 0);

    // R6: fill on the last beat, no gap
    beats = 0; dones = 0; last_idx = -1;
    for (int c = 0; c < 12; c++) begin
      step((c == 0 || c == 4) ? 2'd1 : 2'd0, 1'b0);
      if (o_rsp == 2'd1) begin beats++; last_idx = c; end
      if (o_done) dones++;
    end
    chk(beats == 8, "R6 fill on last beat beats", beats, 8);
    chk(last_idx == 8, "R6 no gap after last beat", last_idx, 8);
    chk(dones == 2, "R8 done count on-last case", dones, 2);

    // R6 R7: back-to-back fills n = 1..7
    for (int n = 1; n <= 7; n++) begin
      beats = 0; dones = 0; last_idx = -1; bad = 0;
      for (int c = 0; c < 4*n + 3; c++) begin
        step((c < n) ? 2'd1 : 2'd0, 1'b0);
        if (o_rsp == 2'd1) begin beats++; last_idx = c; end
        if (o_done) begin dones++; if (beats % 4 != 0) bad++; end
        if (o_on != (c >= 1 && c <= 4*n)) bad++;
      end
      chk(beats == 4*n, "R6 back-to-back beats", beats, 4*n);
      chk(last_idx == 4*n, "R6 contiguous beats", last_idx, 4*n);
      chk(dones == n && bad == 0, "R7 R8 ongoing/done in back-to-back", bad, 0);
    end

    // R5 R3: stall pattern sweep over 8 cycles
    for (int m = 0; m < 256; m++) begin
      beats = 0; dones = 0; bad = 0;
      step(2'd1, 1'b0);
      for (int c = 0; c < 13; c++) begin
        step(2'd0, (c < 8) ? m[c] : 1'b0);
        if (c < 8 && m[c] && o_rsp != 2'd0) bad++;
        if (o_rsp == 2'd1) beats++;
        if (o_done) begin dones++; if (beats != 4) bad++; end
      end
      chk(beats == 4, "R5 beats under stall", beats, 4);
      chk(dones == 1 && bad == 0, "R5 stall idle and done place", bad, 0);
    end

    // R9: overflow with stall held
    for (int c = 0; c < 8; c++) step(2'd1, 1'b1);
    step(2'd0, 1'b1);
    chk(o_ovf == 1'b1, "R9 overflow set on 8th fill", o_ovf, 1);
    beats = 0; dones = 0;
    for (int c = 0; c < 34; c++) begin
      step(2'd0, 1'b0);
      if (o_rsp == 2'd1) beats++;
      if (o_done) dones++;
    end
    chk(beats == 28 && dones == 7, "R9 only 7 fills served", beats, 28);
    chk(o_ovf == 1'b1, "R9 overflow sticky", o_ovf, 1);

    // R10: async reset mid-burst
    step(2'd1, 1'b0);
    step(2'd0, 1'b0);
    rst_n = 1'b0;
    #1;
    chk(rsp == 2'd0 && !ongoing && !done && !overflow, "R10 async clear", overflow, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    step(2'd0, 1'b0);
    chk(o_rsp == 2'd0 && !o_on, "R10 no leftover beats", o_on, 0);

    // R3 R6 R8: random fills and stalls
    begin
      int fills = 0;
      int outst;
      beats = 0; dones = 0;
      for (int c = 0; c < 3000; c++) begin
        logic f, s;
        outst = fills - dones;
        f = (($urandom % 3) == 0) && (outst < 6);
        s = (($urandom % 4) == 0);
        step(f ? 2'd1 : (($urandom % 2) ? 2'd2 : 2'd0), s);
        if (f) fills++;
        if (o_rsp == 2'd1) beats++;
        if (o_done) dones++;
      end
      for (int c = 0; c < 40; c++) begin
        step(2'd0, 1'b0);
        if (o_rsp == 2'd1) beats++;
        if (o_done) dones++;
      end
      chk(beats == 4*fills, "R3 random total beats", beats, 4*fills);
      chk(dones == fills, "R8 random done count", dones, fills);
      chk(!o_on && !o_ovf, "R7 random drains", o_on, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule